// File: doc/BRIEF.md
# BCD Minute-to-Month Calendar Counter

This block holds the current minute, hour, day of month and month as packed BCD fields and moves them forward by one minute each time a single-cycle minute tick arrives. One tick can ripple through all four fields within the same clock cycle, so the step from the last minute of a month into the next month lands on a single clock edge. Month lengths are fixed: thirty days in April, June, September and November, thirty-one in the other long months, and twenty-eight in February. Leap years are not tracked. The only exception is a February day of 29 loaded by software, which then rolls over normally.

Software loads any field through a write port that takes a 2-bit field select and an 8-bit BCD byte. Bits above the field's width are dropped. A combinational read port returns the field that its own select names. If a write and a tick fall in the same cycle, the write is applied and the tick is lost.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read minute 0x00, hour 0x00, day 0x01 and month 0x01.
- R2: On each accepted tick the minute field counts up in BCD from 0x00 to 0x59, then wraps to 0x00 and passes a carry to the hour field.
- R3: The hour field counts 0x00 to 0x23 on minute carries, then wraps to 0x00 and passes a carry to the day field.
- R4: The day field wraps to 0x01 and carries into the month after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12.
- R5: In month 0x02 the day field wraps from 0x28 to 0x01 and the month becomes 0x03.
- R6: A day of 0x29 written while the month is 0x02 rolls to 0x01 on the next day carry, and the month becomes 0x03.
- R7: The month field counts 0x01 to 0x12 and wraps to 0x01. A tick at month 0x12, day 0x31, 23:59 gives 01-01 00:00 on one clock edge.
- R8: A write with select 0 loads hours from data bits 5:0, select 1 loads minutes from bits 6:0, select 2 loads days from bits 5:0, and select 3 loads months from bits 4:0. Higher bits are ignored, and the new value shows after the next clock edge.
- R9: The read data gives the field named by the read select (same encoding as R8), zero-extended to 8 bits, in the same cycle without a clock edge.
- R10: When a write and a tick occur in the same cycle, only the written field changes, and no field advances.
- R11: With no tick and no write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| min_tick | input | 1 | One-cycle pulse that advances the time by one minute |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 2 | Field selected for writing |
| wr_data | input | 8 | BCD byte to load |
| rd_sel | input | 2 | Field selected for reading |
| rd_data | output | 8 | Selected field, zero-extended |

## Verification
The assertions assume that every value written is valid BCD and lies within its field's counting range, with a day no later than the month's last day (or 0x29 in February). Under that assumption an unsigned comparison against the wrap point matches the calendar order. The stimulus writes only such values. Where it exercises bit masking, the byte's upper bits are set, but the bits that are kept still form a legal value. Ticks arrive as single-cycle pulses separated by idle cycles.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef enum logic [1:0] {
        SEL_HOUR  = 2'd0,
        SEL_MIN   = 2'd1,
        SEL_DAY   = 2'd2,
        SEL_MONTH = 2'd3
    } cal_sel_e;

    localparam int MIN_W   = 7;
    localparam int HOUR_W  = 6;
    localparam int DAY_W   = 6;
    localparam int MONTH_W = 5;

    typedef struct packed {
        logic [MONTH_W-1:0] month;
        logic [DAY_W-1:0]   day;
        logic [HOUR_W-1:0]  hour;
        logic [MIN_W-1:0]   minute;
    } cal_time_t;

    // Two-digit packed BCD increment; a low digit of 9 rolls into the upper digit.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
(
    input  logic [MONTH_W-1:0] month_i,
    output logic [DAY_W-1:0]   last_day_o
);

    localparam logic [DAY_W-1:0] LEN_SHORT = DAY_W'(8'h28);
    localparam logic [DAY_W-1:0] LEN_MID   = DAY_W'(8'h30);
    localparam logic [DAY_W-1:0] LEN_LONG  = DAY_W'(8'h31);

    always_comb begin
        unique case (month_i)
            MONTH_W'(8'h02): last_day_o = LEN_SHORT;
            MONTH_W'(8'h04),
            MONTH_W'(8'h06),
            MONTH_W'(8'h09),
            MONTH_W'(8'h11): last_day_o = LEN_MID;
            default:         last_day_o = LEN_LONG;
        endcase
    end

endmodule

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
    import cal_pkg::*;
#(
    parameter int          W    = 7,
    parameter logic [7:0]  LOW  = 8'h00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic [W-1:0] last_i,
    input  logic         ld_i,
    input  logic [7:0]   ld_val_i,
    output logic [W-1:0] q_o,
    output logic         carry_o
);

    localparam logic [W-1:0] LOW_W = W'(LOW);

    logic [W-1:0] q_d, q_q;
    logic         at_end;
    logic [7:0]   stepped;

    always_comb begin
        at_end  = (q_q >= last_i);
        stepped = bcd_inc(8'(q_q));
        q_d     = q_q;
        carry_o = 1'b0;
        if (ld_i) begin
            q_d = ld_val_i[W-1:0];
        end else if (inc_i) begin
            if (at_end) begin
                q_d     = LOW_W;
                carry_o = 1'b1;
            end else begin
                q_d = stepped[W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= LOW_W;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    // R2/R3/R4/R7: an advance from the last value returns to the low value
    p_field_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i && q_q == last_i) |=> (q_q == LOW_W));

    // R11: no advance and no load leaves the field untouched
    p_field_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !ld_i) |=> $stable(q_q));

    // R8: a load takes the low bits of the byte
    p_field_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> (q_q == $past(ld_val_i[W-1:0])));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       min_tick,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data
);

    localparam logic [MIN_W-1:0]   MIN_LAST   = MIN_W'(8'h59);
    localparam logic [HOUR_W-1:0]  HOUR_LAST  = HOUR_W'(8'h23);
    localparam logic [MONTH_W-1:0] MONTH_LAST = MONTH_W'(8'h12);

    cal_time_t          now;
    logic               adv_min;
    logic               c_min, c_hour, c_day, c_month;
    logic [3:0]         ld_vec;
    logic [DAY_W-1:0]   day_last;

    // Control: a write drops a coincident tick
    always_comb begin
        adv_min = min_tick && !wr_en;
        ld_vec  = '0;
        if (wr_en) ld_vec[wr_sel] = 1'b1;
    end

    cal_month_len u_len (
        .month_i    (now.month),
        .last_day_o (day_last)
    );

    cal_bcd_field #(.W(MIN_W), .LOW(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .inc_i(adv_min), .last_i(MIN_LAST),
        .ld_i(ld_vec[SEL_MIN]), .ld_val_i(wr_data),
        .q_o(now.minute), .carry_o(c_min)
    );

    cal_bcd_field #(.W(HOUR_W), .LOW(8'h00)) u_hour (
        .clk(clk), .rst_n(rst_n), .inc_i(c_min), .last_i(HOUR_LAST),
        .ld_i(ld_vec[SEL_HOUR]), .ld_val_i(wr_data),
        .q_o(now.hour), .carry_o(c_hour)
    );

    cal_bcd_field #(.W(DAY_W), .LOW(8'h01)) u_day (
        .clk(clk), .rst_n(rst_n), .inc_i(c_hour), .last_i(day_last),
        .ld_i(ld_vec[SEL_DAY]), .ld_val_i(wr_data),
        .q_o(now.day), .carry_o(c_day)
    );

    cal_bcd_field #(.W(MONTH_W), .LOW(8'h01)) u_month (
        .clk(clk), .rst_n(rst_n), .inc_i(c_day), .last_i(MONTH_LAST),
        .ld_i(ld_vec[SEL_MONTH]), .ld_val_i(wr_data),
        .q_o(now.month), .carry_o(c_month)
    );

    always_comb begin
        unique case (cal_sel_e'(rd_sel))
            SEL_HOUR:  rd_data = 8'(now.hour);
            SEL_MIN:   rd_data = 8'(now.minute);
            SEL_DAY:   rd_data = 8'(now.day);
            default:   rd_data = 8'(now.month);
        endcase
    end

    logic unused_carry;
    assign unused_carry = c_month;

    // R10: a write beside a tick leaves the other fields as they were
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && min_tick && wr_sel != SEL_MIN) |=> $stable(now.minute));

    // R3: 23:59 plus a tick gives hour 00
    p_hour_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tick && !wr_en && now.minute == MIN_LAST && now.hour == HOUR_LAST)
        |=> (now.hour == '0 && now.minute == '0));

    // R5/R6: February ends at 28 (or a written 29)
    p_feb_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tick && !wr_en && now.minute == MIN_LAST && now.hour == HOUR_LAST
         && now.month == MONTH_W'(8'h02)
         && (now.day == DAY_W'(8'h28) || now.day == DAY_W'(8'h29)))
        |=> (now.day == DAY_W'(8'h01) && now.month == MONTH_W'(8'h03)));

    // R7: year end rolls every field in one edge
    p_year_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tick && !wr_en && now.minute == MIN_LAST && now.hour == HOUR_LAST
         && now.month == MONTH_LAST && now.day == DAY_W'(8'h31))
        |=> (now.month == MONTH_W'(8'h01) && now.day == DAY_W'(8'h01)));

endmodule

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/100ps
module sim_bcd_calendar;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       min_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    int e_min, e_hour, e_day, e_mon;

    always #2 clk = ~clk;

    bcd_calendar u0 (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mlen(input int m);
        if (m == 2) return 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    task automatic model_tick();
        e_min++;
        if (e_min == 60) begin
            e_min = 0; e_hour++;
            if (e_hour == 24) begin
                e_hour = 0; e_day++;
                if (e_day > mlen(e_mon) || (e_mon == 2 && e_day > 28)) begin
                    e_day = 1; e_mon++;
                    if (e_mon == 13) e_mon = 1;
                end
            end
        end
    endtask

    task automatic check_field(input logic [1:0] sel, input int exp, input string req);
        rd_sel = sel;
        #0.1;
        checks++;
        if (rd_data !== to_bcd(exp)) begin
            failures++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, rd_data, to_bcd(exp));
        end
    endtask

    task automatic check_all(input string req);
        check_field(2'd0, e_hour, req);
        check_field(2'd1, e_min,  req);
        check_field(2'd2, e_day,  req);
        check_field(2'd3, e_mon,  req);
    endtask

    task automatic tick();
        @(negedge clk); min_tick = 1'b1;
        @(negedge clk); min_tick = 1'b0;
        model_tick();
    endtask

    task automatic write(input logic [1:0] sel, input logic [7:0] data, input logic with_tick);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data; min_tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; min_tick = 1'b0;
        case (sel)
            2'd0: e_hour = from_bcd(data & 8'h3F);
            2'd1: e_min  = from_bcd(data & 8'h7F);
            2'd2: e_day  = from_bcd(data & 8'h3F);
            default: e_mon = from_bcd(data & 8'h1F);
        endcase
    endtask

    task automatic set_time(input int mo, input int d, input int h, input int mi);
        write(2'd3, to_bcd(mo), 1'b0);
        write(2'd2, to_bcd(d), 1'b0);
        write(2'd0, to_bcd(h), 1'b0);
        write(2'd1, to_bcd(mi), 1'b0);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        e_min = 0; e_hour = 0; e_day = 1; e_mon = 1;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R11: idle cycles hold
        repeat (5) @(negedge clk);
        check_all("R11");

        // R2/R3: a whole day of ticks, every field checked after each
        for (int i = 0; i < 1440; i++) begin
            tick();
            check_all(e_min == 0 ? "R3" : "R2");
        end

        // R4/R5/R7: month ends across the year
        for (int m = 1; m <= 12; m++) begin
            set_time(m, mlen(m), 23, 58);
            check_all("R8");
            tick();
            check_all("R4");
            tick();
            check_all(m == 2 ? "R5" : (m == 12 ? "R7" : "R4"));
        end

        // R6: written Feb 29 rolls into March
        set_time(2, 29, 23, 59);
        check_all("R6");
        tick();
        check_all("R6");

        // R8: upper bits masked per field
        write(2'd1, 8'hD9, 1'b0); check_all("R8");
        write(2'd0, 8'hE3, 1'b0); check_all("R8");
        write(2'd2, 8'hD5, 1'b0); check_all("R8");
        write(2'd3, 8'hF2, 1'b0); check_all("R8");

        // R10: write collides with tick; the tick is dropped
        set_time(6, 30, 23, 59);
        write(2'd0, to_bcd(5), 1'b1);
        check_all("R10");
        write(2'd1, to_bcd(59), 1'b1);
        check_all("R10");

        // R9: read select changes without a clock edge
        @(posedge clk); #1;
        check_field(2'd3, e_mon, "R9");
        check_field(2'd2, e_day, "R9");
        check_field(2'd1, e_min, "R9");
        check_field(2'd0, e_hour, "R9");

        // R11: long idle after activity
        repeat (20) @(negedge clk);
        check_all("R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule